// File: doc/BRIEF.md
# DMA Address Translation Walker

This block turns a device DMA request, given as a virtual start address, a byte count and a direction, into a series of physical transfers. It cuts the request at every 4 KB page boundary. For each piece it reads one 32-bit translation entry from memory through a read port with a valid/ready request and a response-valid return, so memory latency can vary. It then presents a 36-bit physical address and a piece length on an output handshake.

The page-table base and the window start come in as plain inputs from the surrounding register block. A missing mapping, or a write to a page that is not writable, stops the walk. The block then hands a fault status word, the page-aligned faulting address and an interrupt strobe back to the register block. It drops the rest of the request and ends with a completion pulse that carries a fault flag. Moving the data and caching entries are left to other blocks.

Top module: `dma_xlate_walker`

## Requirements
- R1: A request is taken only while `req_ready` is high, which is the idle state only. A `req_valid` seen during a walk has no effect on the pieces produced.
- R2: The entry read address is `(tbl_base << 4) + (((va & ~win_start) >> 10) & ~3)`, formed in 36 bits, where `va` is the address of the current piece.
- R3: Each piece runs from its start address to the next 4 KB boundary, or to the end of the request if that comes first. The first piece starts at the request address, and each later piece starts where the one before it ended.
- R4: A piece's physical address is the entry's bits 31:8 placed at physical bits 35:12, with the virtual address bits 11:0 kept below them.
- R5: Entry bit 1 means valid and bit 2 means writable. A piece faults if bit 1 is 0, or if the request is a write and bit 2 is 0. A faulting piece produces no output, and no later piece is fetched.
- R6: On a fault, `flt_status` is 0xC0820000 for a write and 0xC0860000 for a read. Bit 18 marks a read.
- R7: On a fault, `flt_we` and `irq` pulse together for one cycle. `flt_addr` then holds the faulting piece's virtual address with bits 11:0 cleared.
- R8: Each request ends with `done` high for exactly one cycle, with `done_fault` high only if the request faulted. A zero-length request finishes with no memory read and no output.
- R9: `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready` is seen. The response may arrive any number of cycles later.
- R10: `out_valid`, `out_pa` and `out_len` stay unchanged until `out_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_addr | input | 32 | Virtual start address |
| req_len | input | LEN_W | Byte count |
| req_write | input | 1 | 1 for a device write, 0 for a read |
| tbl_base | input | 32 | Page-table base register value |
| win_start | input | 32 | Start of the translated window |
| mem_req_valid | output | 1 | Entry read requested |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Entry address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 32 | Entry data |
| out_valid | output | 1 | Piece translation available |
| out_ready | input | 1 | Consumer takes the piece |
| out_pa | output | 36 | Physical address of the piece |
| out_len | output | 13 | Piece length in bytes (1 to 4096) |
| flt_we | output | 1 | Fault record strobe |
| flt_status | output | 32 | Fault status word |
| flt_addr | output | 32 | Page-aligned faulting virtual address |
| irq | output | 1 | Fault interrupt strobe |
| done | output | 1 | Request finished |
| done_fault | output | 1 | Finished request faulted |

## Verification
A stale current-address register shows at once on `mem_req_addr`, on the fetch of the next piece, and again one handshake later in `out_pa`. A remaining-count error shows as a wrong `out_len` on the last piece, or as an early or late `done`. The state is wrong in a fault sequence if `out_valid` appears in the cycle after the entry returns, or if `done` is missing one cycle after `flt_we`. The bench checks every fetch address, every piece and every fault record in the cycle where it must appear, so any such error is found within one piece.

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker #(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_write,
  input  logic [31:0]       tbl_base,
  input  logic [31:0]       win_start,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [35:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [35:0]       out_pa,
  output logic [12:0]       out_len,
  output logic              flt_we,
  output logic [31:0]       flt_status,
  output logic [31:0]       flt_addr,
  output logic              irq,
  output logic              done,
  output logic              done_fault
);
  localparam int PG_SHIFT = 12;
  localparam int PG_BYTES = 1 << PG_SHIFT;
  localparam logic [31:0] ST_FAULT = 32'hC082_0000;
  localparam logic [31:0] ST_READ  = 32'h0004_0000;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WAIT, S_CHECK, S_EMIT, S_DONE} st_t;

  st_t              state;
  logic [31:0]      cur;
  logic [LEN_W-1:0] rem;
  logic             wr;
  logic [31:0]      pte;
  logic             faulted;

  logic [LEN_W-1:0] room, chunk;
  logic             bad;

  assign room  = LEN_W'(PG_BYTES) - LEN_W'(cur[PG_SHIFT-1:0]);
  assign chunk = (rem < room) ? rem : room;
  assign bad   = !pte[1] || (wr && !pte[2]);

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_addr  = ({4'b0, tbl_base} << 4)
                       + 36'((((cur & ~win_start) >> 10) & ~32'd3));
  assign out_valid     = (state == S_EMIT);
  assign out_pa        = {pte[31:8], cur[PG_SHIFT-1:0]};
  assign out_len       = chunk[PG_SHIFT:0];
  assign flt_we        = (state == S_CHECK) && bad;
  assign irq           = flt_we;
  assign flt_status    = ST_FAULT | (wr ? 32'd0 : ST_READ);
  assign flt_addr      = {cur[31:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign done          = (state == S_DONE);
  assign done_fault    = done && faulted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cur     <= '0;
      rem     <= '0;
      wr      <= 1'b0;
      pte     <= '0;
      faulted <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          cur     <= req_addr;
          rem     <= req_len;
          wr      <= req_write;
          faulted <= 1'b0;
          state   <= (req_len == '0) ? S_DONE : S_FETCH;
        end
        S_FETCH: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          pte   <= mem_rsp_data;
          state <= S_CHECK;
        end
        S_CHECK: if (bad) begin
          faulted <= 1'b1;
          state   <= S_DONE;
        end else begin
          state <= S_EMIT;
        end
        S_EMIT: if (out_ready) begin
          cur   <= cur + 32'(chunk);
          rem   <= rem - chunk;
          state <= (rem == chunk) ? S_DONE : S_FETCH;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r3_piece_in_page: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != 13'd0) &&
                  (({1'b0, out_len} + 14'(out_pa[11:0])) <= 14'd4096));

  a_r5_no_output_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we |=> !out_valid && !mem_req_valid);

  a_r7_fault_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    flt_we |=> done && done_fault);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pa) && $stable(out_len));
endmodule

// File: tb/dma_xlate_walker_bench.sv
module dma_xlate_walker_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, tbl_base = 32'h0012_3400, win_start = 32'hFF00_0000;
  logic [15:0] req_len = '0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        req_ready, mem_req_valid, out_valid, flt_we, irq, done, done_fault;
  logic [35:0] mem_req_addr, out_pa;
  logic [12:0] out_len;
  logic [31:0] flt_status, flt_addr;

  dma_xlate_walker u_dma_xlate_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write),
    .tbl_base(tbl_base), .win_start(win_start),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_pa(out_pa), .out_len(out_len),
    .flt_we(flt_we), .flt_status(flt_status), .flt_addr(flt_addr), .irq(irq),
    .done(done), .done_fault(done_fault)
  );

  int checks = 0;
  int failures = 0;

  localparam int NV = 8;
  localparam logic [31:0] V_ADDR [NV] = '{32'hFF00_0000, 32'hFF00_0F80, 32'hFF00_2010,
    32'hFF00_5000, 32'hFF00_C800, 32'hF123_4567, 32'hFF00_0FFF, 32'hFF00_4000};
  localparam logic [15:0] V_LEN  [NV] = '{16'h0100, 16'h0200, 16'h3000,
    16'h0010, 16'h1000, 16'h0020, 16'h0001, 16'h1000};
  localparam logic        V_WR   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] V_WIN  [NV] = '{32'hFF00_0000, 32'hFF00_0000, 32'hFF00_0000,
    32'hFF00_0000, 32'hFF00_0000, 32'hF000_0000, 32'hFF00_0000, 32'hFF00_0000};
  localparam int          V_LAT  [NV] = '{0, 1, 3, 2, 1, 4, 0, 5};

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Entry model: page number scrambled from index; read-only when idx%8==5, invalid when idx%16==13
  function automatic logic [31:0] pte_of(input int idx);
    logic [23:0] ppn;
    ppn = 24'(idx * 177 + 24'h0ABCDE);
    return {ppn, idx[0], 4'b0000, (idx % 8 != 5), (idx % 16 != 13), 1'b0};
  endfunction

  task automatic run_req(input logic [31:0] addr, input logic [15:0] len, input logic wr,
                         input logic [31:0] win, input int lat, input logic poke);
    logic [31:0] a, pte, ofs;
    logic [35:0] ea;
    int rem, room, ch, idx, n;
    logic fault_seen, bad;
    win_start = win;
    chk(req_ready, "R1", "ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = addr; req_len = len; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'h0; req_len = 16'h0;
    a = addr; rem = int'(len); fault_seen = 1'b0;
    while (rem > 0 && !fault_seen) begin
      room = 4096 - int'(a[11:0]);
      ch = (rem < room) ? rem : room;
      ofs = a & ~win;
      idx = int'(ofs >> 12);
      ea = ({4'b0, tbl_base} << 4) + 36'(((ofs >> 10) & ~32'd3));
      n = 0;
      while (!mem_req_valid && n < 100) begin @(negedge clk); n++; end
      chk(mem_req_addr == ea, "R2", "entry address", 64'(mem_req_addr), 64'(ea));
      if (lat % 2 == 1) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == ea, "R9", "request held while stalled",
            64'(mem_req_addr), 64'(ea));
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int i = 0; i < lat; i++) begin
        if (poke) begin
          req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_len = 16'h0040; req_write = ~wr;
          chk(!req_ready, "R1", "not ready during walk", 64'(req_ready), 64'd0);
        end
        @(negedge clk);
      end
      req_valid = 1'b0;
      pte = pte_of(idx);
      mem_rsp_valid = 1'b1; mem_rsp_data = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      bad = !pte[1] || (wr && !pte[2]);
      if (bad) begin
        chk(flt_we && irq, "R7", "fault strobe and irq", {62'd0, flt_we, irq}, 64'd3);
        chk(flt_status == (wr ? 32'hC082_0000 : 32'hC086_0000), "R6", "fault status",
            64'(flt_status), wr ? 64'hC082_0000 : 64'hC086_0000);
        chk(flt_addr == {a[31:12], 12'h000}, "R7", "fault address",
            64'(flt_addr), {32'd0, a[31:12], 12'h000});
        fault_seen = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R5", "no output for faulting piece", 64'(out_valid), 64'd0);
      end else begin
        chk(!flt_we, "R5", "no fault on good entry", 64'(flt_we), 64'd0);
        @(negedge clk);
        chk(out_valid && out_pa == {pte[31:8], a[11:0]}, "R4", "physical address",
            64'(out_pa), {28'd0, pte[31:8], a[11:0]});
        chk(out_len == 13'(ch), "R3", "piece length", 64'(out_len), 64'(ch));
        if (lat == 2) begin
          @(negedge clk);
          chk(out_valid && out_len == 13'(ch), "R10", "output held", 64'(out_len), 64'(ch));
        end
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        a = a + 32'(ch); rem = rem - ch;
      end
    end
    chk(done && done_fault == fault_seen && !mem_req_valid, "R8", "completion",
        {62'd0, done, done_fault}, {62'd0, 1'b1, fault_seen});
    @(negedge clk);
    chk(!done && req_ready, "R8", "done is one cycle", {62'd0, done, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !out_valid && !done && !flt_we && !irq,
        "R8", "reset state", {58'd0, req_ready, mem_req_valid, out_valid, done, flt_we, irq},
        64'h20);
    for (int v = 0; v < NV; v++)
      run_req(V_ADDR[v], V_LEN[v], V_WR[v], V_WIN[v], V_LAT[v], 1'b0);
    // R8: zero length finishes without a fetch
    run_req(32'hFF00_3000, 16'h0000, 1'b0, 32'hFF00_0000, 0, 1'b0);
    // R1: requests offered during a walk are ignored, including one that ends in a fault
    run_req(32'hFF00_0F00, 16'h0300, 1'b1, 32'hFF00_0000, 3, 1'b1);
    run_req(32'hFF00_4F00, 16'h0200, 1'b1, 32'hFF00_0000, 2, 1'b1);
    // R3: request spanning pages in a wide window
    run_req(32'hC000_1800, 16'h2000, 1'b0, 32'hC000_0000, 1, 1'b0);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule